// File: doc/BRIEF.md
# Receiver Channel-Status and User-Bit Double Buffer

This block sits behind the subframe decoder of a digital audio receiver. It takes one channel-status bit and one user bit from every subframe and assembles a 192-frame block of each per channel into a working buffer. When the block ends, it copies the working buffer into a host-visible buffer in one step. Control bits decide which parts of that copy go ahead.

The host reads the visible buffer byte by byte through an address port. It can read one channel at a time or both channels interleaved, and it can read either the status bits or the user bits. A small register file holds the control bits. A third register address returns the first status byte of the selected channel. A single output flag reports whether that byte announces pre-emphasis. A block copy never lands while the host is reading, so a read pass never sees a half-updated buffer.

Top module: `chstat_dbuf`

## Requirements
- R1: After reset all control bits are 0, both visible buffers hold zero, every host read returns 0 and `emph` is 0.
- R2: Each `bit_valid` pulse stores `c_bit`/`u_bit` for channel `bit_chan` (0 = A, 1 = B) at frame index n, which is bit n%8 of byte n/8. The visible buffers take the whole block in one copy that follows the channel-B subframe of frame 191.
- R3: Status control bit 5 selects whether host reads return user bytes (1) or status bytes (0).
- R4: With status control bit 4 set, a copy leaves status bytes 0 to 4 of both channels unchanged and updates bytes 5 to 23.
- R5: With status control bit 3 set, no status bits are copied. User bits are still copied.
- R6: With status control bit 1 clear (one-byte mode), address n (0 to 23) returns byte n of the channel picked by status control bit 0 (0 = A, 1 = B). Addresses 24 and above return 0.
- R7: With status control bit 1 set (two-byte mode), address 2n returns byte n of channel A and address 2n+1 returns byte n of channel B. Addresses 48 and above return 0.
- R8: User control bit 2 blocks the user-bit copy, but only while user control bit 5 (block mode) is set. Otherwise the user bits are copied.
- R9: `emph` decodes status byte 0 of the selected channel. If bit 0 is 0, `emph` is 1 when bits 5:3 equal 001. If bit 0 is 1, `emph` is 1 when bits 4:2 equal 011.
- R10: While `host_rd` is high, a due copy waits. It takes place on the first cycle `host_rd` is low.
- R11: Register address 0 reads {0,0,b5,b4,b3,0,b1,b0} and address 1 reads {0,0,b5,0,0,b2,0,0}. Address 2 returns the selected channel's status byte 0, and address 3 reads 0.
- R12: A `blk_start` pulse on a channel-A subframe sets the frame index to 0 whatever count came before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_valid | input | 1 | One subframe's bits are present |
| bit_chan | input | 1 | Subframe channel, 0 = A, 1 = B |
| c_bit | input | 1 | Channel-status bit of the subframe |
| u_bit | input | 1 | User bit of the subframe |
| blk_start | input | 1 | First frame of a block (with channel A) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| host_rd | input | 1 | Host read pass in progress |
| host_addr | input | 6 | Host buffer byte address |
| host_rdata | output | 8 | Host buffer byte |
| emph | output | 1 | Pre-emphasis flag of selected channel |

## Verification
Each block is filled from a seeded hash that differs by channel, by bit kind and by frame. A swap of channels, bytes or bit order, or of status and user data, therefore shows up in at least one of the 24 bytes read back. Successive blocks use new seeds, so the bytes that protection or an inhibit should leave alone can be told apart from bytes that were copied. The pre-emphasis cases set byte 0 to patterns that differ from a positive code in only one field bit or in the format bit. A held read pass and a partial block before the start pulse check the deferral timing and the frame realignment.

// File: rtl/chstat_dbuf_pkg.sv
package chstat_dbuf_pkg;

  typedef struct packed {
    logic bsel;
    logic prot;
    logic c_inh;
    logic two_byte;
    logic chs;
  } sctl_t;

  typedef struct packed {
    logic ublk;
    logic u_inh;
  } uctl_t;

  function automatic logic emph_decode(input logic [7:0] b0);
    if (b0[0]) return (b0[4:2] == 3'b011);
    return (b0[5:3] == 3'b001);
  endfunction

  function automatic logic [7:0] pack_sctl(input sctl_t s);
    return {2'b00, s.bsel, s.prot, s.c_inh, 1'b0, s.two_byte, s.chs};
  endfunction

  function automatic logic [7:0] pack_uctl(input uctl_t u);
    return {2'b00, u.ublk, 2'b00, u.u_inh, 2'b00};
  endfunction

endpackage

// File: rtl/chstat_dbuf_regs.sv
module chstat_dbuf_regs
  import chstat_dbuf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output sctl_t      sctl,
  output uctl_t      uctl
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sctl <= '0;
      uctl <= '0;
    end else if (wr) begin
      if (addr == 2'd0) begin
        sctl.bsel     <= wdata[5];
        sctl.prot     <= wdata[4];
        sctl.c_inh    <= wdata[3];
        sctl.two_byte <= wdata[1];
        sctl.chs      <= wdata[0];
      end else if (addr == 2'd1) begin
        uctl.ublk  <= wdata[5];
        uctl.u_inh <= wdata[2];
      end
    end
  end

endmodule

// File: rtl/chstat_dbuf_assembler.sv
module chstat_dbuf_assembler #(
  parameter int FRAMES = 192
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bit_valid,
  input  logic                   bit_chan,
  input  logic                   c_bit,
  input  logic                   u_bit,
  input  logic                   blk_start,
  output logic [1:0][FRAMES-1:0] d_c,
  output logic [1:0][FRAMES-1:0] d_u,
  output logic                   blk_done
);

  localparam int IDX_W = $clog2(FRAMES);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAMES - 1);

  logic [IDX_W-1:0] frame_idx;
  logic [IDX_W-1:0] a_idx;

  assign a_idx = blk_start ? '0 : frame_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_idx <= '0;
      blk_done  <= 1'b0;
      d_c       <= '0;
      d_u       <= '0;
    end else begin
      blk_done <= 1'b0;
      if (bit_valid) begin
        if (!bit_chan) begin
          d_c[0][a_idx] <= c_bit;
          d_u[0][a_idx] <= u_bit;
          if (blk_start) frame_idx <= '0;
        end else begin
          d_c[1][frame_idx] <= c_bit;
          d_u[1][frame_idx] <= u_bit;
          if (frame_idx == LAST) begin
            frame_idx <= '0;
            blk_done  <= 1'b1;
          end else begin
            frame_idx <= frame_idx + 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/chstat_dbuf_estore.sv
module chstat_dbuf_estore
  import chstat_dbuf_pkg::*;
#(
  parameter int FRAMES     = 192,
  parameter int PROT_BYTES = 5,
  parameter int HA_W       = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0][FRAMES-1:0] d_c,
  input  logic [1:0][FRAMES-1:0] d_u,
  input  logic                   blk_done,
  input  logic                   host_rd,
  input  sctl_t                  sctl,
  input  uctl_t                  uctl,
  input  logic [HA_W-1:0]        host_addr,
  output logic [1:0][FRAMES-1:0] e_c,
  output logic [1:0][FRAMES-1:0] e_u,
  output logic                   copy_fire,
  output logic                   copy_pend,
  output logic [7:0]             host_rdata,
  output logic [7:0]             stat_byte,
  output logic                   emph
);

  localparam int BYTES     = FRAMES / 8;
  localparam int PROT_BITS = PROT_BYTES * 8;

  logic              c_upd;
  logic              u_upd;
  logic [FRAMES-1:0] cm;

  assign c_upd     = !sctl.c_inh;
  assign u_upd     = !(uctl.ublk && uctl.u_inh);
  assign copy_fire = (blk_done || copy_pend) && !host_rd;

  always_comb begin
    for (int i = 0; i < FRAMES; i++) begin
      cm[i] = c_upd && (!sctl.prot || (i >= PROT_BITS));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_c       <= '0;
      e_u       <= '0;
      copy_pend <= 1'b0;
    end else begin
      copy_pend <= (blk_done || copy_pend) && host_rd;
      if (copy_fire) begin
        for (int ch = 0; ch < 2; ch++) begin
          e_c[ch] <= (e_c[ch] & ~cm) | (d_c[ch] & cm);
          if (u_upd) e_u[ch] <= d_u[ch];
        end
      end
    end
  end

  logic              rd_ch;
  logic              rd_ok;
  logic [HA_W-1:0]   rd_idx;
  logic [FRAMES-1:0] src_vec;

  always_comb begin
    if (sctl.two_byte) begin
      rd_ok  = int'(host_addr) < 2 * BYTES;
      rd_ch  = host_addr[0];
      rd_idx = host_addr >> 1;
    end else begin
      rd_ok  = int'(host_addr) < BYTES;
      rd_ch  = sctl.chs;
      rd_idx = host_addr;
    end
    if (!rd_ok) rd_idx = '0;
    src_vec    = sctl.bsel ? e_u[rd_ch] : e_c[rd_ch];
    host_rdata = rd_ok ? src_vec[{rd_idx, 3'b000} +: 8] : 8'h00;
  end

  assign stat_byte = e_c[sctl.chs][7:0];
  assign emph      = emph_decode(stat_byte);

endmodule

// File: rtl/chstat_dbuf.sv
module chstat_dbuf
  import chstat_dbuf_pkg::*;
#(
  parameter int  FRAMES     = 192,
  parameter int  PROT_BYTES = 5,
  localparam int HA_W       = $clog2(FRAMES / 4)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bit_valid,
  input  logic            bit_chan,
  input  logic            c_bit,
  input  logic            u_bit,
  input  logic            blk_start,
  input  logic            reg_wr,
  input  logic [1:0]      reg_addr,
  input  logic [7:0]      reg_wdata,
  output logic [7:0]      reg_rdata,
  input  logic            host_rd,
  input  logic [HA_W-1:0] host_addr,
  output logic [7:0]      host_rdata,
  output logic            emph
);

  sctl_t                  sctl;
  uctl_t                  uctl;
  logic [1:0][FRAMES-1:0] d_c;
  logic [1:0][FRAMES-1:0] d_u;
  logic [1:0][FRAMES-1:0] e_c;
  logic [1:0][FRAMES-1:0] e_u;
  logic                   blk_done;
  logic                   copy_fire;
  logic                   copy_pend;
  logic [7:0]             stat_byte;
  logic                   prot_on;
  logic                   c_inh_on;

  assign prot_on  = sctl.prot;
  assign c_inh_on = sctl.c_inh;

  chstat_dbuf_regs u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (reg_wr),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .sctl  (sctl),
    .uctl  (uctl)
  );

  chstat_dbuf_assembler #(.FRAMES(FRAMES)) u_asm (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_valid (bit_valid),
    .bit_chan  (bit_chan),
    .c_bit     (c_bit),
    .u_bit     (u_bit),
    .blk_start (blk_start),
    .d_c       (d_c),
    .d_u       (d_u),
    .blk_done  (blk_done)
  );

  chstat_dbuf_estore #(
    .FRAMES     (FRAMES),
    .PROT_BYTES (PROT_BYTES),
    .HA_W       (HA_W)
  ) u_est (
    .clk        (clk),
    .rst_n      (rst_n),
    .d_c        (d_c),
    .d_u        (d_u),
    .blk_done   (blk_done),
    .host_rd    (host_rd),
    .sctl       (sctl),
    .uctl       (uctl),
    .host_addr  (host_addr),
    .e_c        (e_c),
    .e_u        (e_u),
    .copy_fire  (copy_fire),
    .copy_pend  (copy_pend),
    .host_rdata (host_rdata),
    .stat_byte  (stat_byte),
    .emph       (emph)
  );

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = pack_sctl(sctl);
      2'd1:    reg_rdata = pack_uctl(uctl);
      2'd2:    reg_rdata = stat_byte;
      default: reg_rdata = 8'h00;
    endcase
  end

endmodule

// File: rtl/chstat_dbuf_chk.sv
module chstat_dbuf_chk #(
  parameter int FRAMES     = 192,
  parameter int PROT_BYTES = 5
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   host_rd,
  input logic                   blk_done,
  input logic                   copy_fire,
  input logic                   copy_pend,
  input logic                   prot_on,
  input logic                   c_inh_on,
  input logic [1:0][FRAMES-1:0] e_c,
  input logic [1:0]             reg_addr,
  input logic [7:0]             reg_rdata
);

  localparam int PB = PROT_BYTES * 8;

  a_r10_copy_waits_read: assert property (@(posedge clk) disable iff (!rst_n)
    copy_fire |-> !host_rd);

  a_r10_blocked_copy_pends: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_done && host_rd) |=> copy_pend);

  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |=> !blk_done);

  a_r5_inhibit_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (copy_fire && c_inh_on) |=> $stable(e_c));

  a_r4_protect_head: assert property (@(posedge clk) disable iff (!rst_n)
    (copy_fire && prot_on) |=> ($stable(e_c[0][PB-1:0]) && $stable(e_c[1][PB-1:0])));

  a_r11_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd0) |-> (reg_rdata[7:6] == 2'b00 && reg_rdata[2] == 1'b0));

endmodule

bind chstat_dbuf chstat_dbuf_chk #(.FRAMES(FRAMES), .PROT_BYTES(PROT_BYTES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .host_rd   (host_rd),
  .blk_done  (blk_done),
  .copy_fire (copy_fire),
  .copy_pend (copy_pend),
  .prot_on   (prot_on),
  .c_inh_on  (c_inh_on),
  .e_c       (e_c),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata)
);

// File: tb/chstat_dbuf_bench.sv
module chstat_dbuf_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NF = 192;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_valid = 1'b0, bit_chan = 1'b0, c_bit = 1'b0, u_bit = 1'b0, blk_start = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       host_rd = 1'b0;
  logic [5:0] host_addr = 6'd0;
  logic [7:0] host_rdata;
  logic       emph;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [NF-1:0] mdc [2];
  logic [NF-1:0] mdu [2];
  logic [NF-1:0] exc [2];
  logic [NF-1:0] exu [2];
  logic s_bsel = 0, s_prot = 0, s_cinh = 0, s_two = 0, s_chs = 0, s_ublk = 0, s_uinh = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chstat_dbuf u_chstat_dbuf (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_chan(bit_chan),
    .c_bit(c_bit), .u_bit(u_bit), .blk_start(blk_start), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .host_rd(host_rd), .host_addr(host_addr), .host_rdata(host_rdata), .emph(emph)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  function automatic logic hbit(int seed, int ch, int kind, int f);
    int h;
    h = ((f * (seed + 3) + ch * 11 + kind * 5 + seed * 13) * 37) % 97;
    return h > 48;
  endfunction

  function automatic logic [7:0] exp_rd(int addr);
    logic [7:0] b;
    int ch, n;
    if (s_two) begin
      if (addr >= 48) return 8'h00;
      ch = addr % 2; n = addr / 2;
    end else begin
      if (addr >= 24) return 8'h00;
      ch = s_chs ? 1 : 0; n = addr;
    end
    for (int k = 0; k < 8; k++) b[k] = s_bsel ? exu[ch][n*8+k] : exc[ch][n*8+k];
    return b;
  endfunction

  function automatic logic exp_emph(logic [7:0] b0);
    if (b0[0]) return (b0 & 8'h1D) == 8'h0D;
    return (b0 & 8'h39) == 8'h08;
  endfunction

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic set_ctrl();
    wr_reg(2'd0, {2'b00, s_bsel, s_prot, s_cinh, 1'b0, s_two, s_chs});
    wr_reg(2'd1, {2'b00, s_ublk, 2'b00, s_uinh, 2'b00});
  endtask

  task automatic send_sub(input logic ch, input logic c, input logic u, input logic st);
    @(negedge clk); bit_valid = 1; bit_chan = ch; c_bit = c; u_bit = u; blk_start = st;
    @(negedge clk); bit_valid = 0; blk_start = 0;
  endtask

  task automatic send_block(input int seed, input logic use_b0, input logic [7:0] b0a, input logic [7:0] b0b);
    for (int f = 0; f < NF; f++) begin
      for (int ch = 0; ch < 2; ch++) begin
        logic c, u;
        c = hbit(seed, ch, 0, f);
        u = hbit(seed, ch, 1, f);
        if (use_b0 && f < 8) c = (ch == 0) ? b0a[f%8] : b0b[f%8];
        mdc[ch][f] = c; mdu[ch][f] = u;
        send_sub(ch[0], c, u, (ch == 0) && (f == 0));
      end
    end
  endtask

  task automatic apply_copy();
    for (int ch = 0; ch < 2; ch++)
      for (int i = 0; i < NF; i++) begin
        if (!s_cinh && (!s_prot || i >= 40)) exc[ch][i] = mdc[ch][i];
        if (!(s_ublk && s_uinh)) exu[ch][i] = mdu[ch][i];
      end
  endtask

  task automatic verify(input string req);
    @(negedge clk); host_rd = 1;
    for (int a = 0; a < 64; a++) begin
      host_addr = 6'(a);
      #1;
      chk(req, host_rdata, exp_rd(a));
    end
    @(negedge clk); host_rd = 0;
  endtask

  task automatic verify_views(input string req);
    logic b, c, t;
    b = s_bsel; c = s_chs; t = s_two;
    s_bsel = 0;
    for (int m = 0; m < 3; m++) begin
      s_two = (m == 2); s_chs = (m == 1);
      set_ctrl(); verify(req);
    end
    s_bsel = 1; s_two = 1; set_ctrl(); verify({req, "/R3"});
    s_bsel = b; s_chs = c; s_two = t; set_ctrl();
  endtask

  task automatic t_reset();
    for (int ch = 0; ch < 2; ch++) begin exc[ch] = '0; exu[ch] = '0; end
    @(negedge clk);
    for (int a = 0; a < 4; a++) begin
      reg_addr = 2'(a); #1; chk("R1 reg", reg_rdata, 8'h00);
    end
    chk("R1 emph", {7'd0, emph}, 8'h00);
    verify("R1 host");
  endtask

  task automatic t_regs();
    wr_reg(2'd0, 8'hFF); reg_addr = 2'd0; #1; chk("R11 sctl", reg_rdata, 8'h3B);
    wr_reg(2'd1, 8'hFF); reg_addr = 2'd1; #1; chk("R11 uctl", reg_rdata, 8'h24);
    reg_addr = 2'd3; #1; chk("R11 addr3", reg_rdata, 8'h00);
    set_ctrl(); reg_addr = 2'd0; #1; chk("R11 clear", reg_rdata, 8'h00);
  endtask

  task automatic t_basic();
    send_block(1, 0, 8'h00, 8'h00);
    repeat (4) @(negedge clk);
    apply_copy();
    verify_views("R2 R6 R7 basic");
  endtask

  task automatic t_protect();
    s_prot = 1; set_ctrl();
    send_block(2, 0, 8'h00, 8'h00);
    repeat (4) @(negedge clk);
    apply_copy();
    verify_views("R4 protect");
    s_prot = 0; set_ctrl();
  endtask

  task automatic t_cinh();
    s_cinh = 1; set_ctrl();
    send_block(3, 0, 8'h00, 8'h00);
    repeat (4) @(negedge clk);
    apply_copy();
    verify_views("R5 c_inhibit");
    s_cinh = 0; set_ctrl();
  endtask

  task automatic t_uinh();
    s_ublk = 1; s_uinh = 1; set_ctrl();
    send_block(4, 0, 8'h00, 8'h00);
    repeat (4) @(negedge clk);
    apply_copy();
    verify_views("R8 u_inhibit block");
    s_ublk = 0; set_ctrl();
    send_block(5, 0, 8'h00, 8'h00);
    repeat (4) @(negedge clk);
    apply_copy();
    verify_views("R8 u_inhibit ignored");
    s_uinh = 0; set_ctrl();
  endtask

  task automatic t_emph(input logic [7:0] a0, input logic [7:0] b0, input int seed);
    send_block(seed, 1, a0, b0);
    repeat (4) @(negedge clk);
    apply_copy();
    s_chs = 0; set_ctrl(); reg_addr = 2'd2; #1;
    chk("R9 emph A", {7'd0, emph}, {7'd0, exp_emph(a0)});
    chk("R11 status A", reg_rdata, a0);
    s_chs = 1; set_ctrl(); reg_addr = 2'd2; #1;
    chk("R9 emph B", {7'd0, emph}, {7'd0, exp_emph(b0)});
    chk("R11 status B", reg_rdata, b0);
    s_chs = 0; set_ctrl();
  endtask

  task automatic t_defer();
    @(negedge clk); host_rd = 1;
    send_block(8, 0, 8'h00, 8'h00);
    host_rd = 1;
    repeat (6) @(negedge clk);
    for (int a = 0; a < 24; a++) begin
      host_addr = 6'(a); #1; chk("R10 held", host_rdata, exp_rd(a));
    end
    host_rd = 0;
    repeat (3) @(negedge clk);
    apply_copy();
    verify("R10 released");
  endtask

  task automatic t_realign();
    for (int f = 0; f < 10; f++) begin
      send_sub(1'b0, 1'b1, 1'b1, 1'b0);
      send_sub(1'b1, 1'b1, 1'b1, 1'b0);
    end
    send_block(9, 0, 8'h00, 8'h00);
    repeat (4) @(negedge clk);
    apply_copy();
    verify_views("R12 realign");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_reset();
    t_regs();
    t_basic();
    t_protect();
    t_cinh();
    t_uinh();
    t_emph(8'h08, 8'h05, 6);
    t_emph(8'h18, 8'h0D, 7);
    t_emph(8'h09, 8'h0C, 10);
    t_defer();
    t_realign();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule